// File: doc/BRIEF.md
# Dual-Tone Signalling Generator

This block produces a pair of independent signalling tones and adds them into one signed sample stream for a telephone audio path. It runs from a 1.2 MHz system clock. Each tone is a stepped, symmetric staircase. Its rate comes from an 8-bit code written by the controller. The high tone runs through 6 steps and the low tone through 14 steps. Each step lasts as many clocks as the effective divisor of that tone's code.

Writing the low-tone code starts a burst. A timer runs for a fixed number of clocks, 96 ms at the nominal clock rate. When the timer has expired, each tone finishes its current cycle and halts where its waveform comes back to the reference level. The controller can hold off the timer with a continuous-mode input. Some codes have a special meaning: code 2 silences a tone, which gives single-tone output, and codes 0 and 1 select the longest divisors. A code written while the tone is running changes its rate without resetting its phase.

Top module: `dual_tone_gen`

## Requirements
- R1: After reset, `sample_o` is 0 and `active_o` is 0.
- R2: While running, the high tone holds each step for D clocks and repeats a 6-step sequence with levels {0, +1, +1, 0, -1, -1} x HI_AMP, starting at step 0. Its period is 6·D clocks.
- R3: While running, the low tone holds each step for D clocks and repeats a 14-step sequence with levels {0,1,2,3,3,2,1,0,-1,-2,-3,-3,-2,-1} x LO_AMP, starting at step 0. Its period is 14·D clocks.
- R4: `sample_o` is the sum of the levels of the running tones. A tone that is not running contributes 0. `active_o` is 1 exactly while at least one tone runs.
- R5: A low-tone write made while no tone runs starts every tone whose code is not 2 at step 0, from the clock edge that takes the write. A high-tone write alone starts nothing.
- R6: With `cont_i` low, a tone of period P stops at the first clock edge k after the starting edge (k counted from 0) for which k is a multiple of P and k ≥ BURST_CYCLES+1. It stops as it would re-enter step 0.
- R7: While `cont_i` is high, the burst timer holds its value and the tones keep running. Once `cont_i` falls, the timer resumes and the R6 stop rule applies.
- R8: Code 2 silences its tone. Writing 2 to a running tone stops it at that edge.
- R9: Code 0 gives divisor 257 and code 1 gives divisor 256. Any other code other than 2 is its own divisor.
- R10: A code written while its tone runs takes effect on the current step count without resetting the step index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (1.2 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_hi_i | input | 1 | Write strobe for the high-tone code |
| wr_lo_i | input | 1 | Write strobe for the low-tone code; also starts a burst |
| wr_data_i | input | 8 | Code value for either write |
| cont_i | input | 1 | Continuous mode; holds the burst timer |
| sample_o | output | SW | Signed sum of the two tone levels |
| active_o | output | 1 | High while either tone runs |

## Verification
The assertions assume that the two write strobes are never high together. They also assume that each strobe lasts one clock and that `rst_ni` is low from time zero until the first edges. The bench drives every strobe for exactly one cycle, always from the falling edge. It waits for a burst to finish before it issues the next start, so the phase-reset rule of R5 is always exercised from idle. The random codes are limited to 3..40 with a short burst length, so every burst ends within a few hundred clocks. Sums of the amplitudes stay far inside the sample width.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
  localparam logic [7:0] SILENT_CODE = 8'd2;
  localparam int DIV_W = 9;

  function automatic logic [DIV_W-1:0] eff_div(input logic [7:0] code);
    case (code)
      8'd0:    eff_div = 9'd257;
      8'd1:    eff_div = 9'd256;
      default: eff_div = {1'b0, code};
    endcase
  endfunction
endpackage

// File: rtl/dtg_tone.sv
`timescale 1ns/1ps
module dtg_tone
  import dtg_pkg::*;
#(
  parameter int N   = 6,
  parameter int AMP = 1000,
  parameter int SW  = 16,
  localparam int SPW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           data_i,
  input  logic                 start_i,
  input  logic                 stop_req_i,
  output logic                 run_o,
  output logic [SPW-1:0]       step_o,
  output logic signed [SW-1:0] level_o
);
  localparam int HALF = N / 2;

  logic [7:0]       code_q, code_nx;
  logic [DIV_W-1:0] cnt_q, div_nx;
  logic [SPW-1:0]   step_q;
  logic             run_q, silence_wr;

  assign code_nx    = we_i ? data_i : code_q;
  assign div_nx     = eff_div(code_nx);
  assign silence_wr = we_i && (data_i == SILENT_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (we_i) code_q <= data_i;
      if (silence_wr) begin
        run_q  <= 1'b0;
        step_q <= '0;
        cnt_q  <= '0;
      end else if (start_i && !run_q) begin
        run_q  <= (code_nx != SILENT_CODE);
        step_q <= '0;
        cnt_q  <= '0;
      end else if (run_q) begin
        if (cnt_q >= div_nx - 9'd1) begin
          cnt_q <= '0;
          if (step_q == SPW'(N-1)) begin
            step_q <= '0;
            if (stop_req_i) run_q <= 1'b0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  int s_i, j_i, mag_i, lvl_i;
  always_comb begin
    s_i   = int'(step_q);
    j_i   = (s_i < HALF) ? s_i : s_i - HALF;
    mag_i = (j_i < HALF - j_i) ? j_i : HALF - j_i;
    lvl_i = (s_i < HALF) ? mag_i * AMP : -(mag_i * AMP);
    level_o = run_q ? SW'(lvl_i) : '0;
  end

  assign run_o  = run_q;
  assign step_o = step_q;
endmodule

// File: rtl/dtg_burst.sv
`timescale 1ns/1ps
module dtg_burst #(
  parameter int CYC = 115200,
  localparam int TW = $clog2(CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          cont_i,
  input  logic          any_run_i,
  output logic          expired_o,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q;
  logic          burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= TW'(CYC);
      burst_q <= 1'b1;
    end else begin
      if (burst_q && !cont_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (burst_q && !any_run_i) burst_q <= 1'b0;
    end
  end

  assign expired_o = burst_q && !cont_i && (cnt_q == '0);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/dual_tone_gen.sv
`timescale 1ns/1ps
module dual_tone_gen #(
  parameter int BURST_CYCLES = 115200,
  parameter int HI_AMP       = 1000,
  parameter int LO_AMP       = 1000,
  parameter int SW           = 16,
  localparam int HI_N = 6,
  localparam int LO_N = 14,
  localparam int HSW  = $clog2(HI_N),
  localparam int LSW  = $clog2(LO_N),
  localparam int TW   = $clog2(BURST_CYCLES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_hi_i,
  input  logic                 wr_lo_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 cont_i,
  output logic signed [SW-1:0] sample_o,
  output logic                 active_o
);
  logic                 hi_run, lo_run, expired;
  logic [HSW-1:0]       hi_step;
  logic [LSW-1:0]       lo_step;
  logic [TW-1:0]        tmr_cnt;
  logic signed [SW-1:0] hi_lvl, lo_lvl;

  dtg_burst #(.CYC(BURST_CYCLES)) u_burst (
    .clk_i, .rst_ni,
    .load_i    (wr_lo_i),
    .cont_i,
    .any_run_i (hi_run || lo_run),
    .expired_o (expired),
    .cnt_o     (tmr_cnt)
  );

  dtg_tone #(.N(HI_N), .AMP(HI_AMP), .SW(SW)) u_hi (
    .clk_i, .rst_ni,
    .we_i       (wr_hi_i),
    .data_i     (wr_data_i),
    .start_i    (wr_lo_i),
    .stop_req_i (expired),
    .run_o      (hi_run),
    .step_o     (hi_step),
    .level_o    (hi_lvl)
  );

  dtg_tone #(.N(LO_N), .AMP(LO_AMP), .SW(SW)) u_lo (
    .clk_i, .rst_ni,
    .we_i       (wr_lo_i),
    .data_i     (wr_data_i),
    .start_i    (wr_lo_i),
    .stop_req_i (expired),
    .run_o      (lo_run),
    .step_o     (lo_step),
    .level_o    (lo_lvl)
  );

  assign sample_o = hi_lvl + lo_lvl;
  assign active_o = hi_run | lo_run;
endmodule

// File: rtl/dual_tone_gen_chk.sv
`timescale 1ns/1ps
module dual_tone_gen_chk #(
  parameter int SW  = 16,
  parameter int HSW = 3,
  parameter int LSW = 4,
  parameter int TW  = 17
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_hi_i,
  input logic                 wr_lo_i,
  input logic [7:0]           wr_data_i,
  input logic                 cont_i,
  input logic signed [SW-1:0] sample_o,
  input logic                 active_o,
  input logic                 hi_run,
  input logic                 lo_run,
  input logic [HSW-1:0]       hi_step,
  input logic [LSW-1:0]       lo_step,
  input logic [TW-1:0]        tmr_cnt
);
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> sample_o == '0); // R4
  AST_LO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && wr_data_i != 8'd2 |=> lo_run); // R5
  AST_HI_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && wr_data_i == 8'd2 |=> !hi_run); // R8
  AST_HI_STOP_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_run) |-> ($past(int'(hi_step)) == 5 || $past(wr_hi_i && wr_data_i == 8'd2))); // R6
  AST_LO_STOP_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lo_run) |-> ($past(int'(lo_step)) == 13 || $past(wr_lo_i && wr_data_i == 8'd2))); // R6
  AST_NO_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run && tmr_cnt != '0 && !(wr_hi_i && wr_data_i == 8'd2) |=> hi_run); // R6
  AST_CONT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_i && lo_run && !(wr_lo_i && wr_data_i == 8'd2) |=> lo_run); // R7
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_i && !wr_lo_i |=> $stable(tmr_cnt)); // R7
endmodule

bind dual_tone_gen dual_tone_gen_chk #(.SW(SW), .HSW(HSW), .LSW(LSW), .TW(TW)) u_chk (.*);

// File: tb/sim_dual_tone_gen.sv
`timescale 1ns/1ps
module sim_dual_tone_gen;
  localparam int B   = 300;
  localparam int AMP = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_hi = 0, wr_lo = 0, cont = 0;
  logic [7:0] wdata = '0;
  logic signed [15:0] sample;
  logic active;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_tone_gen #(.BURST_CYCLES(B), .HI_AMP(AMP), .LO_AMP(AMP), .SW(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wr_data_i(wdata), .cont_i(cont), .sample_o(sample), .active_o(active));

  function automatic int lvl(int n, int s);
    int half, j, mag;
    half = n / 2;
    j    = (s < half) ? s : s - half;
    mag  = (j < half - j) ? j : half - j;
    return (s < half) ? mag * AMP : -(mag * AMP);
  endfunction

  function automatic int eff(int code);
    if (code == 0) return 257;
    if (code == 1) return 256;
    return code;
  endfunction

  function automatic int stop_edge(int n, int d);
    int per;
    per = n * d;
    return ((B + per) / per) * per;
  endfunction

  task automatic chk(input string req, input int exp_s, input bit exp_a);
    n_chk++;
    if (int'(sample) != exp_s || active !== exp_a) begin
      n_fail++;
      $display("FAIL %s: sample=%0d active=%0b expected sample=%0d active=%0b",
               req, sample, active, exp_s, exp_a);
    end
  endtask

  task automatic wr(input bit hi, input int code);
    @(negedge clk);
    wr_hi = hi; wr_lo = !hi; wdata = 8'(code);
    @(negedge clk);
    wr_hi = 0; wr_lo = 0;
  endtask

  // start a burst and check every cycle against the R2/R3/R6 formulas
  task automatic run_burst(input int hc, input int lc, input string req);
    int dh, dl, sh, sl, last;
    bit hs, ls;
    cont = 0;
    wr(1, hc);
    dh = eff(hc); dl = eff(lc);
    hs = (hc == 2); ls = (lc == 2);
    sh = hs ? 0 : stop_edge(6, dh);
    sl = ls ? 0 : stop_edge(14, dl);
    last = (sh > sl) ? sh : sl;
    wr(0, lc);
    for (int j = 0; j <= last + 4; j++) begin
      int e; bit ra, rb;
      ra = j < sh; rb = j < sl;
      e  = (ra ? lvl(6, (j / dh) % 6) : 0) + (rb ? lvl(14, (j / dl) % 14) : 0);
      chk(req, e, ra || rb);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 0, 0);

    // R5: high-tone write alone starts nothing
    wr(1, 7);
    for (int k = 0; k < 20; k++) begin chk("R5 hi write only", 0, 0); @(negedge clk); end

    run_burst(3, 5, "R2 R3 R4 R6 directed");
    run_burst(2, 7, "R8 hi silent");
    run_burst(9, 2, "R8 lo silent");
    run_burst(0, 1, "R9 default codes");
    run_burst(1, 0, "R9 default codes swapped");
    for (int r = 0; r < 6; r++)
      run_burst(3 + int'($urandom % 38), 3 + int'($urandom % 38), "R2 R3 R6 random");

    // R7 / R10: continuous mode with a code change mid-step
    cont = 1;
    wr(1, 10);
    wr(0, 2);
    for (int j = 0; j < 20; j++) begin
      chk("R7 cont hi tone", lvl(6, (j / 10) % 6), 1);
      @(negedge clk);
    end
    chk("R10 before change", AMP, 1);
    wr_hi = 1; wdata = 8'd8;
    @(negedge clk);
    wr_hi = 0;
    chk("R10 step kept after write", AMP, 1);
    for (int k = 22; k <= 28; k++) begin
      @(negedge clk);
      chk("R10 new divisor", (k < 28) ? AMP : 0, 1);
    end
    for (int k = 0; k < 2 * B; k++) begin
      @(negedge clk);
      if (!active) begin chk("R7 cont keeps running", 0, 1); break; end
    end
    n_chk++;
    cont = 0;
    for (int k = 0; k < B + 60 && active; k++) @(negedge clk);
    chk("R7 stops after cont falls", 0, 0);

    // R8: silencing a running tone
    cont = 1;
    wr(1, 5);
    wr(0, 2);
    repeat (7) @(negedge clk);
    chk("R8 running before silence", lvl(6, (8 / 5) % 6), 1);
    wr_hi = 1; wdata = 8'd2;
    @(negedge clk);
    wr_hi = 0;
    chk("R8 silenced at once", 0, 0);
    cont = 0;
    repeat (5) @(negedge clk);
    chk("R8 stays silent", 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule